// File: doc/BRIEF.md
# UART Ring-Buffer DMA Channel

This block is one DMA channel that sits between a UART byte stream and a circular buffer in system memory. It has two directions. In receive it takes bytes from the UART side, writes each one into the ring and moves its own write pointer. In transmit it fetches bytes from the ring, hands them to the UART side and moves its own read pointer. Software owns the opposite pointer and moves it to hand over data or space.

Software sets the channel up through a small word-addressed register file: base address, ring length, threshold, pointers and control bits. It reads back the byte count in the ring and the free space. The channel raises a level interrupt from sticky flags when those counts cross the threshold. It supports an enable, a stop request that hardware acknowledges, a transmit flush bit that clears itself, and a warm reset. Memory traffic uses a one-byte request/acknowledge port with a 32-bit address, and only one request may be open at a time.

Top module: `uart_vfifo_dma`

## Requirements
- R1: After reset the enable, stop, flush, interrupt flags, interrupt enables, base, length, threshold and both pointers read 0. irq, mem_req, rx_ready and tx_valid are low.
- R2: A pointer holds a byte offset in bits 15:0 and a lap bit in bit 16. When a hardware step moves the offset past length-1, the offset goes back to 0 and the lap bit inverts. The length must be a power of two no larger than 65536.
- R3: The valid count is write offset minus read offset when the lap bits match, and write offset plus length minus read offset when they differ. The left count is length minus valid.
- R4: In receive, a byte offered while the channel is enabled, not stopping, idle and has left > 0 is accepted. It is then written with one request at base + write offset, and the write pointer steps only after the acknowledge. rx_ready stays low while left is 0.
- R5: In transmit, when the channel is enabled, not stopping and valid > 0, it reads the byte at base + read offset and presents it on tx_data with tx_valid. The read pointer steps when tx_ready accepts it.
- R6: Software writes to the software-owned pointer take effect: the read pointer in receive, the write pointer in transmit. Writes to the hardware-owned pointer are ignored.
- R7: Flag bits set while the channel is enabled. In receive, bit 0 sets when valid ≥ threshold and bit 1 sets when left = 0. In transmit, bit 0 sets when left ≥ threshold. irq is the OR of flags masked by the interrupt-enable bits. A write to the flag register clears the bits written as 1 in receive, and clears bit 0 whatever the value in transmit. A flag whose condition still holds sets again.
- R8: While stop bit 0 is 1 the channel starts no new transfer. Once idle it clears the enable, and it keeps the enable cleared until software writes stop back to 0.
- R9: Writing 1 to flush bit 0 sets the flush bit. In transmit it reads 1 until valid is 0 and the channel is idle, then clears itself. In receive it clears on the next cycle.
- R10: Writing 1 to bit 0 of the reset register clears the enable, the flush bit and the hardware-owned pointer, and returns the engine to idle. The software-owned pointer is kept.
- R11: Register byte offsets are: flags 0x00, interrupt enable 0x04, enable 0x08, reset 0x0C, stop 0x10, flush 0x14, base 0x1C, length 0x24, threshold 0x28, write pointer 0x2C, read pointer 0x30, valid 0x3C, left 0x40, debug 0x50. In the enable register, bit 0 is enable and bit 1 is direction (1 = transmit). Debug bits 1:0 give the engine state: 0 idle, 1 memory access, 2 presenting a transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte accepted this cycle |
| tx_valid | output | 1 | Transmit byte presented |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit byte taken |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a ring write (receive), 0 for a read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
A register write is captured at the next rising edge. Its effect on readback, counts and irq is sampled at the following falling edge, and the stop acknowledge, which drops the enable one edge later, is read a full cycle after that. A received byte raises mem_req on the edge that accepts it, and the write pointer steps on the edge that sees the acknowledge. A transmit byte appears on tx_data on the edge after the read acknowledge, and flush falls one edge after the last read-pointer step. The memory and UART monitors compare every write and every transmitted byte against queued expectations at the falling edge where the handshake is visible. Pointer and count checks wait a few cycles after the traffic stops, which is past the last of these edges.

// File: rtl/uart_vfifo_pkg.sv
`timescale 1ns/1ps
package uart_vfifo_pkg;
  localparam logic [7:0] OFS_FLAG  = 8'h00;
  localparam logic [7:0] OFS_INTEN = 8'h04;
  localparam logic [7:0] OFS_EN    = 8'h08;
  localparam logic [7:0] OFS_RST   = 8'h0C;
  localparam logic [7:0] OFS_STOP  = 8'h10;
  localparam logic [7:0] OFS_FLUSH = 8'h14;
  localparam logic [7:0] OFS_BASE  = 8'h1C;
  localparam logic [7:0] OFS_LEN   = 8'h24;
  localparam logic [7:0] OFS_THR   = 8'h28;
  localparam logic [7:0] OFS_WPT   = 8'h2C;
  localparam logic [7:0] OFS_RPT   = 8'h30;
  localparam logic [7:0] OFS_VALID = 8'h3C;
  localparam logic [7:0] OFS_LEFT  = 8'h40;
  localparam logic [7:0] OFS_DBG   = 8'h50;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_MEM  = 2'd1,
    ENG_SEND = 2'd2
  } eng_state_e;
endpackage

// File: rtl/uart_vfifo_ring_math.sv
`timescale 1ns/1ps
module uart_vfifo_ring_math #(
  parameter int PW = 17
) (
  input  logic [PW-1:0] wpt_i,
  input  logic [PW-1:0] rpt_i,
  input  logic [PW-1:0] len_i,
  output logic [PW-1:0] valid_o,
  output logic [PW-1:0] left_o
);
  localparam int OFFW = PW - 1;

  logic [PW-1:0] woff, roff;
  logic          same_lap;

  always_comb begin
    woff     = {1'b0, wpt_i[OFFW-1:0]};
    roff     = {1'b0, rpt_i[OFFW-1:0]};
    same_lap = (wpt_i[PW-1] == rpt_i[PW-1]);
    valid_o  = same_lap ? (woff - roff) : (woff + len_i - roff);
    left_o   = len_i - valid_o;
  end
endmodule

// File: rtl/uart_vfifo_engine.sv
`timescale 1ns/1ps
module uart_vfifo_engine
  import uart_vfifo_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 8,
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir_tx_i,
  input  logic            go_i,
  input  logic            abort_i,
  input  logic            valid_nz_i,
  input  logic            left_nz_i,
  input  logic [AW-1:0]   base_i,
  input  logic [OFFW-1:0] hw_off_i,
  input  logic            rx_valid_i,
  input  logic [DW-1:0]   rx_data_i,
  output logic            rx_ready_o,
  output logic            tx_valid_o,
  output logic [DW-1:0]   tx_data_o,
  input  logic            tx_ready_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_ack_i,
  output logic            adv_o,
  output eng_state_e      state_o
);
  eng_state_e  state_q, state_d;
  logic [DW-1:0] byte_q, byte_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] start_addr;

  assign start_addr = base_i + AW'(hw_off_i);

  always_comb begin
    state_d = state_q;
    byte_d  = byte_q;
    addr_d  = addr_q;
    adv_o   = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (go_i) begin
          if (!dir_tx_i && rx_valid_i && left_nz_i) begin
            byte_d  = rx_data_i;
            addr_d  = start_addr;
            state_d = ENG_MEM;
          end else if (dir_tx_i && valid_nz_i) begin
            addr_d  = start_addr;
            state_d = ENG_MEM;
          end
        end
      end
      ENG_MEM: begin
        if (mem_ack_i) begin
          if (dir_tx_i) begin
            byte_d  = mem_rdata_i;
            state_d = ENG_SEND;
          end else begin
            adv_o   = 1'b1;
            state_d = ENG_IDLE;
          end
        end
      end
      ENG_SEND: begin
        if (tx_ready_i) begin
          adv_o   = 1'b1;
          state_d = ENG_IDLE;
        end
      end
      default: state_d = ENG_IDLE;
    endcase
    if (abort_i) begin
      state_d = ENG_IDLE;
      adv_o   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      byte_q  <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (byte_d != byte_q) byte_q <= byte_d;
      if (addr_d != addr_q) addr_q <= addr_d;
    end
  end

  assign rx_ready_o  = (state_q == ENG_IDLE) && go_i && !dir_tx_i && left_nz_i;
  assign mem_req_o   = (state_q == ENG_MEM);
  assign mem_we_o    = !dir_tx_i;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = byte_q;
  assign tx_valid_o  = (state_q == ENG_SEND);
  assign tx_data_o   = byte_q;
  assign state_o     = state_q;

  // R4: an open request keeps its address until acknowledged
  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i && !abort_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R5: a presented transmit byte stays until taken
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i && !abort_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: rtl/uart_vfifo_regs.sv
`timescale 1ns/1ps
module uart_vfifo_regs
  import uart_vfifo_pkg::*;
#(
  parameter int AW  = 32,
  parameter int PW  = 17,
  parameter int RAW = 8,
  parameter int RDW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [RDW-1:0] reg_wdata_i,
  output logic [RDW-1:0] reg_rdata_o,
  input  logic [PW-1:0]  valid_i,
  input  logic [PW-1:0]  left_i,
  input  logic           adv_i,
  input  eng_state_e     state_i,
  output logic [PW-1:0]  wpt_o,
  output logic [PW-1:0]  rpt_o,
  output logic [PW-1:0]  len_o,
  output logic [AW-1:0]  base_o,
  output logic           dir_tx_o,
  output logic           go_o,
  output logic           warm_o,
  output logic           irq_o
);
  localparam int OFFW = PW - 1;
  localparam logic [OFFW-1:0] ONE = OFFW'(1);

  logic          en_q, en_d, dir_q, dir_d, stop_q, stop_d, flush_q, flush_d;
  logic [AW-1:0] base_q, base_d;
  logic [PW-1:0] len_q, len_d, thr_q, thr_d, wpt_q, wpt_d, rpt_q, rpt_d;
  logic [1:0]    flag_q, flag_d, inten_q, inten_d, set_vec, clr_vec;
  logic [OFFW-1:0] len_mask;
  logic          idle;

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p,
                                             input logic [OFFW-1:0] m);
    logic [OFFW-1:0] n;
    n = (p[OFFW-1:0] + ONE) & m;
    return {p[PW-1] ^ (n == '0), n};
  endfunction

  function automatic logic wr(input logic we, input logic [RAW-1:0] a,
                              input logic [7:0] ofs);
    return we && (a == RAW'(ofs));
  endfunction

  assign idle     = (state_i == ENG_IDLE);
  assign len_mask = len_q[OFFW-1:0] - ONE;
  assign warm_o   = wr(reg_we_i, reg_addr_i, OFS_RST) && reg_wdata_i[0];

  always_comb begin
    en_d    = en_q;
    dir_d   = dir_q;
    stop_d  = stop_q;
    flush_d = flush_q;
    base_d  = base_q;
    len_d   = len_q;
    thr_d   = thr_q;
    wpt_d   = wpt_q;
    rpt_d   = rpt_q;
    inten_d = inten_q;
    if (wr(reg_we_i, reg_addr_i, OFS_EN))    begin en_d = reg_wdata_i[0]; dir_d = reg_wdata_i[1]; end
    if (stop_q && idle)                      en_d = 1'b0;
    if (wr(reg_we_i, reg_addr_i, OFS_STOP))  stop_d = reg_wdata_i[0];
    if (flush_q && (!dir_q || (valid_i == '0 && idle))) flush_d = 1'b0;
    if (wr(reg_we_i, reg_addr_i, OFS_FLUSH) && reg_wdata_i[0]) flush_d = 1'b1;
    if (wr(reg_we_i, reg_addr_i, OFS_BASE))  base_d  = reg_wdata_i[AW-1:0];
    if (wr(reg_we_i, reg_addr_i, OFS_LEN))   len_d   = reg_wdata_i[PW-1:0];
    if (wr(reg_we_i, reg_addr_i, OFS_THR))   thr_d   = reg_wdata_i[PW-1:0];
    if (wr(reg_we_i, reg_addr_i, OFS_INTEN)) inten_d = reg_wdata_i[1:0];
    if (!dir_q) begin
      if (adv_i) wpt_d = ptr_step(wpt_q, len_mask);
      if (wr(reg_we_i, reg_addr_i, OFS_RPT)) rpt_d = reg_wdata_i[PW-1:0];
      if (warm_o) wpt_d = '0;
    end else begin
      if (adv_i) rpt_d = ptr_step(rpt_q, len_mask);
      if (wr(reg_we_i, reg_addr_i, OFS_WPT)) wpt_d = reg_wdata_i[PW-1:0];
      if (warm_o) rpt_d = '0;
    end
    if (warm_o) begin
      en_d    = 1'b0;
      flush_d = 1'b0;
    end
    // flags: set has priority over clear
    if (!en_q)      set_vec = 2'b00;
    else if (dir_q) set_vec = {1'b0, left_i >= thr_q};
    else            set_vec = {left_i == '0, valid_i >= thr_q};
    if (!wr(reg_we_i, reg_addr_i, OFS_FLAG)) clr_vec = 2'b00;
    else if (dir_q)                          clr_vec = 2'b01;
    else                                     clr_vec = reg_wdata_i[1:0];
    flag_d = (flag_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; dir_q <= 1'b0; stop_q <= 1'b0; flush_q <= 1'b0;
      base_q <= '0; len_q <= '0; thr_q <= '0;
      wpt_q <= '0; rpt_q <= '0; flag_q <= '0; inten_q <= '0;
    end else begin
      en_q <= en_d; dir_q <= dir_d; stop_q <= stop_d; flush_q <= flush_d;
      base_q <= base_d; len_q <= len_d; thr_q <= thr_d;
      wpt_q <= wpt_d; rpt_q <= rpt_d; flag_q <= flag_d; inten_q <= inten_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RAW'(OFS_FLAG):  reg_rdata_o = RDW'(flag_q);
      RAW'(OFS_INTEN): reg_rdata_o = RDW'(inten_q);
      RAW'(OFS_EN):    reg_rdata_o = RDW'({dir_q, en_q});
      RAW'(OFS_STOP):  reg_rdata_o = RDW'(stop_q);
      RAW'(OFS_FLUSH): reg_rdata_o = RDW'(flush_q);
      RAW'(OFS_BASE):  reg_rdata_o = RDW'(base_q);
      RAW'(OFS_LEN):   reg_rdata_o = RDW'(len_q);
      RAW'(OFS_THR):   reg_rdata_o = RDW'(thr_q);
      RAW'(OFS_WPT):   reg_rdata_o = RDW'(wpt_q);
      RAW'(OFS_RPT):   reg_rdata_o = RDW'(rpt_q);
      RAW'(OFS_VALID): reg_rdata_o = RDW'(valid_i);
      RAW'(OFS_LEFT):  reg_rdata_o = RDW'(left_i);
      RAW'(OFS_DBG):   reg_rdata_o = RDW'(state_i);
      default:         reg_rdata_o = '0;
    endcase
  end

  assign wpt_o    = wpt_q;
  assign rpt_o    = rpt_q;
  assign len_o    = len_q;
  assign base_o   = base_q;
  assign dir_tx_o = dir_q;
  assign go_o     = en_q && !stop_q;
  assign irq_o    = |(flag_q & inten_q);

  // R3: the ring never holds more than its length
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i <= len_q);

  // R8: an idle channel with a pending stop drops its enable
  assert_stop_drops_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && idle && en_q) |=> !en_q);

  // R9: flush ends only when drained, in receive, or on warm reset
  assert_flush_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_q) |-> $past(warm_o || !dir_q || (valid_i == '0)));

  // R6: in receive the write pointer moves only by an engine step or warm reset
  assert_hw_ptr_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_q && !adv_i && !warm_o) |=> $stable(wpt_q));
endmodule

// File: rtl/uart_vfifo_dma.sv
`timescale 1ns/1ps
module uart_vfifo_dma
  import uart_vfifo_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 8,
  parameter int PW  = 17,
  parameter int RAW = 8,
  parameter int RDW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  output logic [RDW-1:0] reg_rdata,
  output logic           irq,
  input  logic           rx_valid,
  input  logic [DW-1:0]  rx_data,
  output logic           rx_ready,
  output logic           tx_valid,
  output logic [DW-1:0]  tx_data,
  input  logic           tx_ready,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack
);
  localparam int OFFW = PW - 1;

  logic [PW-1:0] wpt, rpt, len, valid, left;
  logic [AW-1:0] base;
  logic          dir_tx, go, warm, adv;
  logic [OFFW-1:0] hw_off;
  eng_state_e    state;

  assign hw_off = dir_tx ? rpt[OFFW-1:0] : wpt[OFFW-1:0];

  uart_vfifo_regs #(.AW(AW), .PW(PW), .RAW(RAW), .RDW(RDW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .valid_i(valid), .left_i(left), .adv_i(adv), .state_i(state),
    .wpt_o(wpt), .rpt_o(rpt), .len_o(len), .base_o(base),
    .dir_tx_o(dir_tx), .go_o(go), .warm_o(warm), .irq_o(irq)
  );

  uart_vfifo_ring_math #(.PW(PW)) u_math (
    .wpt_i(wpt), .rpt_i(rpt), .len_i(len), .valid_o(valid), .left_o(left)
  );

  uart_vfifo_engine #(.AW(AW), .DW(DW), .OFFW(OFFW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .dir_tx_i(dir_tx), .go_i(go), .abort_i(warm),
    .valid_nz_i(valid != '0), .left_nz_i(left != '0),
    .base_i(base), .hw_off_i(hw_off),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .adv_o(adv), .state_o(state)
  );
endmodule

// File: tb/uart_vfifo_dma_bench.sv
`timescale 1ns/1ps
module uart_vfifo_dma_bench;
  logic        clk, rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, rx_valid, rx_ready, tx_valid, tx_ready;
  logic [7:0]  rx_data, tx_data, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;

  int tests = 0;
  int fails = 0;
  logic [7:0]  bmem [0:255];
  logic [39:0] exp_wr_q [$];
  logic [7:0]  exp_tx_q [$];

  uart_vfifo_dma u_uart_vfifo_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: offers one receive byte and queues the expected memory write
  task automatic rx_push(input logic [7:0] b, input logic [31:0] addr);
    exp_wr_q.push_back({addr, b});
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // memory model and write monitor
  initial begin
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          bmem[mem_addr[7:0]] = mem_wdata;
          tests++;
          if (exp_wr_q.size() == 0) begin
            fails++;
            $display("FAIL R4 unexpected write actual=0x%0h/0x%0h expected=none", mem_addr, mem_wdata);
          end else begin
            logic [39:0] e;
            e = exp_wr_q.pop_front();
            if ({mem_addr, mem_wdata} !== e) begin
              fails++;
              $display("FAIL R4 write actual=0x%0h expected=0x%0h", {mem_addr, mem_wdata}, e);
            end
          end
        end else mem_rdata = bmem[mem_addr[7:0]];
      end
    end
  end

  // transmit monitor
  initial begin
    forever begin
      @(negedge clk);
      if (tx_valid && tx_ready) begin
        tests++;
        if (exp_tx_q.size() == 0) begin
          fails++;
          $display("FAIL R5 unexpected byte actual=0x%0h expected=none", tx_data);
        end else begin
          logic [7:0] e;
          e = exp_tx_q.pop_front();
          if (tx_data !== e) begin
            fails++;
            $display("FAIL R5 tx byte actual=0x%0h expected=0x%0h", tx_data, e);
          end
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; tx_ready = 1'b1;
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rd_chk("R1 en", 8'h08, 0);
    rd_chk("R1 wpt", 8'h2C, 0);
    rd_chk("R1 rpt", 8'h30, 0);
    rd_chk("R1 flags", 8'h00, 0);
    rd_chk("R1 len", 8'h24, 0);
    chk("R1 outputs", {28'd0, irq, mem_req, rx_ready, tx_valid}, 0);

    // receive setup: base 0x40, length 8, threshold 6
    wr(8'h1C, 32'h40); wr(8'h24, 8); wr(8'h28, 6); wr(8'h04, 3); wr(8'h08, 1);
    for (int i = 0; i < 5; i++) rx_push(8'h10 + 8'(i), 32'h40 + i);
    idle_cycles(3);
    rd_chk("R2 wpt after 5", 8'h2C, 5);
    rd_chk("R3 valid 5", 8'h3C, 5);
    rd_chk("R3 left 3", 8'h40, 3);
    rd_chk("R7 no flag below thr", 8'h00, 0);
    wr(8'h30, 3);
    rd_chk("R6 sw rpt", 8'h30, 3);
    rd_chk("R3 valid 2", 8'h3C, 2);
    wr(8'h2C, 32'h1234);
    rd_chk("R6 hw wpt ignored", 8'h2C, 5);
    for (int i = 0; i < 6; i++) rx_push(8'h20 + 8'(i), 32'h40 + ((5 + i) % 8));
    idle_cycles(3);
    rd_chk("R2 wpt wrapped", 8'h2C, 32'h10003);
    rd_chk("R3 valid across lap", 8'h3C, 8);
    rd_chk("R3 left zero", 8'h40, 0);
    chk("R4 rx_ready low when full", {31'd0, rx_ready}, 0);
    rd_chk("R7 both rx flags", 8'h00, 3);
    chk("R7 irq", {31'd0, irq}, 1);
    wr(8'h30, 32'h10003);
    rd_chk("R3 drained", 8'h3C, 0);
    wr(8'h00, 2);
    rd_chk("R7 w1c bit1", 8'h00, 1);
    wr(8'h00, 1);
    rd_chk("R7 w1c bit0", 8'h00, 0);
    chk("R7 irq cleared", {31'd0, irq}, 0);
    wr(8'h14, 1);
    idle_cycles(1);
    rd_chk("R9 rx flush self clears", 8'h14, 0);

    // stop handshake
    wr(8'h10, 1);
    idle_cycles(1);
    rd_chk("R8 enable dropped", 8'h08, 0);
    rd_chk("R8 stop held", 8'h10, 1);
    wr(8'h08, 1);
    idle_cycles(1);
    rd_chk("R8 enable held low while stop", 8'h08, 0);
    wr(8'h10, 0);
    wr(8'h08, 1);
    rd_chk("R8 enable after stop clear", 8'h08, 1);

    // warm reset
    wr(8'h0C, 1);
    rd_chk("R10 en cleared", 8'h08, 0);
    rd_chk("R10 wpt cleared", 8'h2C, 0);
    rd_chk("R10 rpt kept", 8'h30, 32'h10003);

    // transmit: base 0x80, length 4
    wr(8'h08, 2);
    wr(8'h0C, 1);
    rd_chk("R10 tx hw rpt cleared", 8'h30, 0);
    wr(8'h2C, 0); wr(8'h1C, 32'h80); wr(8'h24, 4); wr(8'h28, 3); wr(8'h04, 1);
    bmem[8'h80] = 8'hA0; bmem[8'h81] = 8'hA1; bmem[8'h82] = 8'hA2; bmem[8'h83] = 8'hA3;
    exp_tx_q.push_back(8'hA0); exp_tx_q.push_back(8'hA1); exp_tx_q.push_back(8'hA2);
    wr(8'h2C, 3);
    rd_chk("R6 tx sw wpt", 8'h2C, 3);
    wr(8'h14, 1);
    idle_cycles(2);
    rd_chk("R9 flush pending", 8'h14, 1);
    wr(8'h08, 3);
    for (int i = 0; i < 40; i++) begin
      rd(8'h14, v);
      if (v == 0) break;
      @(negedge clk);
    end
    rd_chk("R9 flush drained", 8'h14, 0);
    rd_chk("R5 rpt after send", 8'h30, 3);
    rd_chk("R7 tx flag", 8'h00, 1);
    chk("R7 tx irq", {31'd0, irq}, 1);
    wr(8'h28, 5);
    wr(8'h00, 0);
    rd_chk("R7 tx clear any write", 8'h00, 0);
    bmem[8'h80] = 8'hB0;
    exp_tx_q.push_back(8'hA3); exp_tx_q.push_back(8'hB0);
    wr(8'h2C, 32'h10001);
    idle_cycles(12);
    rd_chk("R2 tx rpt wrapped", 8'h30, 32'h10001);
    rd_chk("R3 tx valid empty", 8'h3C, 0);
    rd_chk("R11 debug idle", 8'h50, 0);
    rd_chk("R11 enable dir bit", 8'h08, 3);
    chk("R4 writes drained", exp_wr_q.size(), 0);
    chk("R5 bytes drained", exp_tx_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule